// File: doc/BRIEF.md
# Reset Qualifier and Boot Mode Selector

This block sits between the chip's reset pin and the rest of the core. It divides the oscillator clock into a machine-cycle tick. On each tick it samples the reset pin, the program-store strobe pin and the external-access pin, after bringing each through a two-flop synchroniser. It asserts the internal core reset once the reset pin has been high for two machine cycles. It releases the core on the first tick that sees the pin low.

While reset is held, the strobe pin is normally idle high. If the pin has been high for more than ten machine cycles and a host then pulls the strobe pin from high to low, the block records a request for flash programming by an external host. When reset is released, the block sets the boot mode flag to that request. The flag then holds until the next internal reset assertion.

A lock input indicates that a flash block is secured. While it is set, the effective external-access level is the value sampled during reset, not the live pin.

Top module: `rst_mode_seq`

## Requirements
- R1: `mc_tick_o` is high for one clock in every OSC_PER_MC clocks (default 12), and the reset pin and strobe pin are sampled only on those ticks.
- R2: `core_rst_o` rises on the second consecutive tick that samples the reset pin high. A reset pin pulse seen on a single tick leaves `core_rst_o` low.
- R3: `core_rst_o` falls on the first tick that samples the reset pin low, and changes on no other clock.
- R4: A high-to-low change of the synchronised strobe pin between two ticks sets host mode (`host_mode_o` = 1) at release. The change must be seen on a tick that is at least the eleventh consecutive high sample of the reset pin.
- R5: A strobe fall seen on the tenth or an earlier consecutive high sample of the reset pin is ignored, and release gives normal mode (`host_mode_o` = 0).
- R6: A reset hold with no strobe fall gives normal mode at release.
- R7: The count of high samples saturates rather than wraps, so a qualifying strobe fall after a hold of any length still selects host mode.
- R8: `host_mode_o` changes only on the release tick or on the tick where `core_rst_o` rises, where it clears to 0. It is never 1 while `core_rst_o` is 1.
- R9: With `lock_i` = 1, `ea_o` is the external-access pin value sampled on the last tick of reset and does not follow the pin afterwards. With `lock_i` = 0, `ea_o` follows the pin through the two-flop synchroniser.
- R10: While `rst_ni` is low, `core_rst_o` = 1, `host_mode_o` = 0 and `ea_o` = 0 (with the external-access pin low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| psen_pin_i | input | 1 | Program-store strobe pin as an input, asynchronous |
| ea_pin_i | input | 1 | External-access pin, asynchronous |
| lock_i | input | 1 | Flash security lock active |
| mc_tick_o | output | 1 | Machine-cycle tick |
| core_rst_o | output | 1 | Internal core reset, active high |
| host_mode_o | output | 1 | 1 = external-host programming mode, 0 = normal run |
| ea_o | output | 1 | Effective external-access level |

## Verification
The assertions take `lock_i` to be quasi-static: the access-pin hold check applies only when the lock was set on two consecutive clocks. They take the pins to be asynchronous but slow compared with the tick.

The bench changes pins only right after a tick edge, which leaves eleven clocks for the synchroniser before the next sample. It changes `lock_i` only while the core is in reset or while no latched value is under check. It never pulses a pin for less than a machine cycle.

// File: rtl/rms_pkg.sv
package rms_pkg;
  localparam int unsigned OSC_PER_MC_DEF  = 12;
  localparam int unsigned RST_MC_DEF      = 2;
  localparam int unsigned ENTRY_MC_DEF    = 10;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    RUN_MODE  = 1'b0,
    HOST_MODE = 1'b1
  } boot_mode_e;
endpackage

// File: rtl/rms_sync.sv
module rms_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rms_tick_div.sv
module rms_tick_div #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/rms_hold_cnt.sv
module rms_hold_cnt #(
  parameter int unsigned CAP = 11,
  parameter int unsigned CW  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          level_i,
  output logic [CW-1:0] held_o
);
  localparam logic [CW-1:0] CAP_V = CW'(CAP);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) begin
      if (!level_i)            cnt_q <= '0;
      else if (cnt_q != CAP_V) cnt_q <= cnt_q + 1'b1;
    end
  end

  // value before this tick's update: consecutive high samples already seen
  assign held_o = cnt_q;
endmodule

// File: rtl/rms_mode_ctl.sv
module rms_mode_ctl
  import rms_pkg::*;
#(
  parameter int unsigned CW       = 4,
  parameter int unsigned RST_MC   = 2,
  parameter int unsigned ENTRY_MC = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          pin_rst_i,
  input  logic          psen_i,
  input  logic [CW-1:0] held_i,
  output logic          core_rst_o,
  output boot_mode_e    mode_o
);
  localparam logic [CW-1:0] ASSERT_V = CW'(RST_MC - 1);
  localparam logic [CW-1:0] ENTRY_V  = CW'(ENTRY_MC);

  logic       psen_prev_q;
  logic       host_req_q;
  logic       core_rst_q;
  boot_mode_e mode_q;

  logic assert_now, strobe_fall, armed;

  assign assert_now  = pin_rst_i && (held_i >= ASSERT_V);
  assign strobe_fall = psen_prev_q && !psen_i;
  assign armed       = pin_rst_i && (held_i >= ENTRY_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psen_prev_q <= 1'b0;
      host_req_q  <= 1'b0;
      core_rst_q  <= 1'b1;
      mode_q      <= RUN_MODE;
    end else if (tick_i) begin
      psen_prev_q <= psen_i;
      if (pin_rst_i) begin
        if (assert_now && !core_rst_q) begin
          core_rst_q <= 1'b1;
          mode_q     <= RUN_MODE;
          host_req_q <= 1'b0;
        end else if (armed && strobe_fall) begin
          host_req_q <= 1'b1;
        end
      end else begin
        if (core_rst_q) begin
          mode_q     <= host_req_q ? HOST_MODE : RUN_MODE;
          core_rst_q <= 1'b0;
        end
        host_req_q <= 1'b0;
      end
    end
  end

  assign core_rst_o = core_rst_q;
  assign mode_o     = mode_q;
endmodule

// File: rtl/rst_mode_seq.sv
module rst_mode_seq
  import rms_pkg::*;
#(
  parameter int unsigned OSC_PER_MC  = OSC_PER_MC_DEF,
  parameter int unsigned RST_MC      = RST_MC_DEF,
  parameter int unsigned ENTRY_MC    = ENTRY_MC_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_pin_i,
  input  logic psen_pin_i,
  input  logic ea_pin_i,
  input  logic lock_i,
  output logic mc_tick_o,
  output logic core_rst_o,
  output logic host_mode_o,
  output logic ea_o
);
  localparam int unsigned HOLD_CAP = (ENTRY_MC > RST_MC ? ENTRY_MC : RST_MC) + 1;
  localparam int unsigned HOLD_W   = $clog2(HOLD_CAP + 1);
  localparam int unsigned NPIN     = 3;

  logic [NPIN-1:0] pins_raw, pins_s;
  logic            rst_s, psen_s, ea_s;
  logic            tick;
  logic [HOLD_W-1:0] held;
  logic            core_rst;
  boot_mode_e      mode;
  logic            ea_lat_q;

  assign pins_raw = {ea_pin_i, psen_pin_i, rst_pin_i};

  rms_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign rst_s  = pins_s[0];
  assign psen_s = pins_s[1];
  assign ea_s   = pins_s[2];

  rms_tick_div #(.DIV(OSC_PER_MC)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  rms_hold_cnt #(.CAP(HOLD_CAP), .CW(HOLD_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .level_i(rst_s),
    .held_o (held)
  );

  rms_mode_ctl #(.CW(HOLD_W), .RST_MC(RST_MC), .ENTRY_MC(ENTRY_MC)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .pin_rst_i (rst_s),
    .psen_i    (psen_s),
    .held_i    (held),
    .core_rst_o(core_rst),
    .mode_o    (mode)
  );

  // access level captured on every tick spent in reset, last one wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ea_lat_q <= 1'b0;
    else if (tick && core_rst) ea_lat_q <= ea_s;
  end

  assign mc_tick_o   = tick;
  assign core_rst_o  = core_rst;
  assign host_mode_o = (mode == HOST_MODE);
  assign ea_o        = lock_i ? ea_lat_q : ea_s;
endmodule

// File: rtl/rms_checker.sv
module rms_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic lock_i,
  input logic mc_tick_o,
  input logic core_rst_o,
  input logic host_mode_o,
  input logic ea_o
);
  assert_tick_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_tick_o |=> !mc_tick_o);

  assert_rst_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mc_tick_o |=> $stable(core_rst_o));

  assert_host_at_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_mode_o) |-> $fell(core_rst_o));

  assert_no_host_in_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> !host_mode_o);

  assert_host_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_o && $past(!core_rst_o)) |-> $stable(host_mode_o));

  assert_ea_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && $past(lock_i) && !core_rst_o && $past(!core_rst_o)) |-> $stable(ea_o));
endmodule

bind rst_mode_seq rms_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lock_i     (lock_i),
  .mc_tick_o  (mc_tick_o),
  .core_rst_o (core_rst_o),
  .host_mode_o(host_mode_o),
  .ea_o       (ea_o)
);

// File: tb/rst_mode_seq_tb.sv
`timescale 1ns/1ps
module rst_mode_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_pin = 1'b0, psen_pin = 1'b1, ea_pin = 1'b0, lock = 1'b0;
  logic mc_tick, core_rst, host_mode, ea;
  int   n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  rst_mode_seq u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rst_pin_i  (rst_pin),
    .psen_pin_i (psen_pin),
    .ea_pin_i   (ea_pin),
    .lock_i     (lock),
    .mc_tick_o  (mc_tick),
    .core_rst_o (core_rst),
    .host_mode_o(host_mode),
    .ea_o       (ea)
  );

  // hold cycles, strobe fall step (0 = none), expected host mode
  localparam int NV = 9;
  localparam int VEC_HOLD[NV] = '{12, 12, 20, 5, 15, 11, 3, 40, 14};
  localparam int VEC_FALL[NV] = '{11, 10, 15, 0, 0, 11, 3, 38, 1};
  localparam int VEC_HOST[NV] = '{1, 0, 1, 0, 0, 1, 0, 1, 0};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance past the next tick edge, landing on a negedge
  task automatic step();
    @(negedge clk);
    while (!mc_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(input int hold, input int fall, input int exp, input string req);
    rst_pin  = 1'b1;
    psen_pin = 1'b1;
    for (int s = 1; s <= hold; s++) begin
      if (s == fall) psen_pin = 1'b0;
      step();
    end
    check("R2 core reset held", core_rst, 1);
    rst_pin  = 1'b0;
    psen_pin = 1'b1;
    step();
    check("R3 core reset released", core_rst, 0);
    check(req, host_mode, exp);
  endtask

  initial begin
    int per;
    repeat (3) @(negedge clk);
    check("R10 core_rst in reset", core_rst, 1);
    check("R10 host_mode in reset", host_mode, 0);
    check("R10 ea in reset", ea, 0);
    rst_n = 1'b1;

    // R1 tick period
    @(negedge clk);
    while (!mc_tick) @(negedge clk);
    per = 0;
    @(negedge clk);
    per++;
    while (!mc_tick) begin @(negedge clk); per++; end
    check("R1 tick period", per, 12);

    for (int v = 0; v < NV; v++) begin
      string req;
      if (VEC_HOLD[v] > 30)      req = "R7 saturated hold";
      else if (VEC_HOST[v] == 1) req = "R4 host entry";
      else if (VEC_FALL[v] != 0) req = "R5 early fall ignored";
      else                       req = "R6 no fall normal";
      run_vec(VEC_HOLD[v], VEC_FALL[v], VEC_HOST[v], req);
    end

    // R8 host mode held, then cleared on next reset assertion
    run_vec(12, 11, 1, "R4 host entry");
    repeat (40) @(negedge clk);
    check("R8 host stable after release", host_mode, 1);
    rst_pin = 1'b1;
    step();
    check("R2 one tick high no reset", core_rst, 0);
    check("R8 host kept before assertion", host_mode, 1);
    step();
    check("R2 reset after two ticks", core_rst, 1);
    check("R8 host cleared on assertion", host_mode, 0);
    rst_pin = 1'b0;
    step();
    check("R3 release", core_rst, 0);
    check("R6 normal after release", host_mode, 0);

    // R2 single-tick pulse ignored
    rst_pin = 1'b1;
    step();
    rst_pin = 1'b0;
    step();
    check("R2 single tick pulse", core_rst, 0);
    step();
    check("R2 single tick pulse later", core_rst, 0);

    // R9 locked access level
    lock   = 1'b1;
    ea_pin = 1'b1;
    run_vec(4, 0, 0, "R6 no fall normal");
    ea_pin = 1'b0;
    repeat (30) @(negedge clk);
    check("R9 locked ea held", ea, 1);
    lock = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 unlocked ea follows", ea, 0);
    ea_pin = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 unlocked ea follows high", ea, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule